// File: doc/BRIEF.md
# Two-Port Synchronous Static Memory with Selectable Read Latency

This block is a word-organised memory that two independent agents reach at the same time. Each side, left and right, has its own clock, reset, address, write data, read data and per-lane drive flags. Each side also has its own pair of chip selects (one active low, one active high), a read/not-write line, per-lane active-low byte selects, an active-low output enable and a latency select. A word is `LANES` lanes of `LANE_W` bits. The default is two 9-bit lanes, so a word is 18 bits. Lane index 1 is the upper lane and lane index 0 is the lower lane. Data outputs are a plain bus plus one drive flag per lane, so no tri-state is needed. A drive flag at 1 means that lane of the bus carries valid read data.

Each side runs in one of two modes, chosen by its latency pin. In flow-through mode, read data and drive flags appear after the first rising edge. In pipelined mode they appear one edge later, from an extra output register. The port-select and read/write state in pipelined mode also passes through two register stages, so a deselect takes two edges to clear the outputs. The byte-lane selects always pass through a single stage. The output enable acts without any clock.

If both sides write one address in the same cycle, the stored result is undefined. If one side reads an address that the other side writes in the same cycle, it gets either the old word or the new one.

Top module: `twin_port_sram`

## Requirements
- R1: While reset is asserted, and after release with no access, both ports' drive flags are all 0.
- R2: A port is selected only when `*_csn` is 0 and `*_cs` is 1. A deselected port drives no lane, and a write presented while deselected leaves the memory unchanged.
- R3: A selected write (`*_rnw`=0) stores data bits [9k+8:9k] exactly when `*_bsel_n[k]` is 0. Bit 1 is the upper lane, bits 17..9; bit 0 is the lower lane, bits 8..0. A lane whose select is 1 keeps its stored value.
- R4: A selected read (`*_rnw`=1) with output enable 0 sets drive flag k to 1 only for the lanes whose `*_bsel_n[k]` is 0, and each driven lane carries the stored bits of that lane.
- R5: With both byte selects at 1, a selected access neither drives a lane nor changes the memory.
- R6: A write cycle does not drive the writing port's outputs.
- R7: Output enable at 1 clears all drive flags at once, with no clock edge. Returning it to 0 restores the registered read.
- R8: In flow-through mode (`*_pipe`=0), read data and drive flags are valid after the first rising edge, and a deselect clears the drive flags after that same edge.
- R9: In pipelined mode (`*_pipe`=1), read data and drive flags are valid after the second rising edge. Select and read/write state take two stages, so a deselect clears the drive flags only after the second edge.
- R10: In pipelined mode the lane mask applied to the output is the byte-select value sampled at the most recent edge, not the one sampled with the read.
- R11: A word written on one port is read back on the other. Same-cycle writes to different addresses on both ports both take effect. A same-cycle read of an address being written by the other port returns the old word or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left port clock |
| l_rst_n | input | 1 | Left port asynchronous active-low reset of the read pipeline |
| l_pipe | input | 1 | Left latency select: 0 flow-through, 1 pipelined |
| l_csn | input | 1 | Left active-low chip select |
| l_cs | input | 1 | Left active-high chip select |
| l_rnw | input | 1 | Left read (1) or write (0) |
| l_qen_n | input | 1 | Left asynchronous active-low output enable |
| l_bsel_n | input | LANES | Left active-low byte-lane selects |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | LANE_W*LANES | Left write data |
| l_rdata | output | LANE_W*LANES | Left read data |
| l_drive | output | LANES | Left per-lane drive flags |
| r_clk | input | 1 | Right port clock |
| r_rst_n | input | 1 | Right port asynchronous active-low reset of the read pipeline |
| r_pipe | input | 1 | Right latency select: 0 flow-through, 1 pipelined |
| r_csn | input | 1 | Right active-low chip select |
| r_cs | input | 1 | Right active-high chip select |
| r_rnw | input | 1 | Right read (1) or write (0) |
| r_qen_n | input | 1 | Right asynchronous active-low output enable |
| r_bsel_n | input | LANES | Right active-low byte-lane selects |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | LANE_W*LANES | Right write data |
| r_rdata | output | LANE_W*LANES | Right read data |
| r_drive | output | LANES | Right per-lane drive flags |

## Verification
The memory is first filled over every address from the left port and read back over every address from the right port. It is then overwritten from the right port with the lane chosen by address parity and read back from the left. These two passes tell real cross-port storage apart from per-port storage, and separate true lane masking from whole-word writes. Reads with each byte-select pattern distinguish the drive flags from the data. Reads with each deselect pattern, and a write-then-read sequence, show that nothing leaks onto the outputs. Back-to-back reads in both modes, followed by deselects, measure the one-edge and two-edge latencies. A changed lane mask on the cycle after a pipelined read shows that the lane selects take a single stage. Toggling output enable between clock edges shows the asynchronous disable.

// File: rtl/tps_pkg.sv
package tps_pkg;

  // A port is live only with the low-true select low and the high-true select high.
  function automatic logic port_on(input logic csn, input logic cs);
    return !csn && cs;
  endfunction

  // Each bank keeps one flag per word and lane. Equal flags mean the left bank
  // holds the newest copy; unequal flags mean the right bank does.
  function automatic logic left_newest(input logic flag_l, input logic flag_r);
    return flag_l == flag_r;
  endfunction

  // Flag value a bank stores on its own write so that it becomes the newest.
  function automatic logic claim_flag(input logic is_left, input logic peer_flag);
    return is_left ? peer_flag : !peer_flag;
  endfunction

endpackage

// File: rtl/tps_bank.sv
module tps_bank #(
  parameter int  ADDR_W  = 8,
  parameter int  LANE_W  = 9,
  parameter int  LANES   = 2,
  parameter bit  IS_LEFT = 1'b1
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [LANES-1:0]          wr_lanes,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANE_W*LANES-1:0]   wr_data,
  input  logic [LANES-1:0]          peer_flag,
  input  logic [ADDR_W-1:0]         rd_addr_a,
  input  logic [ADDR_W-1:0]         rd_addr_b,
  output logic [LANE_W*LANES-1:0]   q_a,
  output logic [LANE_W*LANES-1:0]   q_b,
  output logic [LANES-1:0]          f_a,
  output logic [LANES-1:0]          f_b
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic              flags [DEPTH];
    logic              lane_wr;

    assign lane_wr = wr_en && wr_lanes[g];

    initial begin
      for (int k = 0; k < DEPTH; k++) flags[k] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (lane_wr) begin
        cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        flags[wr_addr] <= tps_pkg::claim_flag(IS_LEFT, peer_flag[g]);
      end
    end

    assign q_a[g*LANE_W +: LANE_W] = cells[rd_addr_a];
    assign q_b[g*LANE_W +: LANE_W] = cells[rd_addr_b];
    assign f_a[g] = flags[rd_addr_a];
    assign f_b[g] = flags[rd_addr_b];
  end

endmodule

// File: rtl/tps_port_pipe.sv
module tps_port_pipe #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pipe,
  input  logic                      csn,
  input  logic                      cs,
  input  logic                      rnw,
  input  logic                      qen_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic [LANE_W*LANES-1:0]   mem_word,
  output logic [LANE_W*LANES-1:0]   rdata,
  output logic [LANES-1:0]          drive,
  output logic                      wr_fire,
  output logic [LANES-1:0]          wr_lanes
);
  localparam int DATA_W = LANE_W * LANES;

  logic              on_now;
  logic              rd_fire;
  logic              en_s1, en_s2, rd_s1, rd_s2;
  logic [LANES-1:0]  lane_s1;
  logic [DATA_W-1:0] word_s1, word_s2;
  logic              en_out, rd_out, live;
  logic [DATA_W-1:0] word_out;

  assign on_now   = tps_pkg::port_on(csn, cs);
  assign wr_fire  = on_now && !rnw;
  assign rd_fire  = on_now && rnw;
  assign wr_lanes = ~bsel_n;

  // Select and read/write state: stage 1 always, stage 2 feeds pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1   <= 1'b0;
      rd_s1   <= 1'b0;
      en_s2   <= 1'b0;
      rd_s2   <= 1'b0;
      lane_s1 <= '0;
    end else begin
      en_s1   <= on_now;
      rd_s1   <= rnw;
      en_s2   <= en_s1;
      rd_s2   <= rd_s1;
      lane_s1 <= ~bsel_n;
    end
  end

  // Read data: captured on a read, then one more register for pipelined mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_s1 <= '0;
      word_s2 <= '0;
    end else begin
      if (rd_fire) word_s1 <= mem_word;
      word_s2 <= word_s1;
    end
  end

  always_comb begin
    if (pipe) begin
      en_out   = en_s2;
      rd_out   = rd_s2;
      word_out = word_s2;
    end else begin
      en_out   = en_s1;
      rd_out   = rd_s1;
      word_out = word_s1;
    end
  end

  // Output enable is applied combinationally, outside every register.
  assign live  = en_out && rd_out && !qen_n;
  assign rdata = word_out;

  for (genvar g = 0; g < LANES; g++) begin : g_drv
    assign drive[g] = live && lane_s1[g];
  end

endmodule

// File: rtl/twin_port_sram.sv
module twin_port_sram #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                      l_clk,
  input  logic                      l_rst_n,
  input  logic                      l_pipe,
  input  logic                      l_csn,
  input  logic                      l_cs,
  input  logic                      l_rnw,
  input  logic                      l_qen_n,
  input  logic [LANES-1:0]          l_bsel_n,
  input  logic [ADDR_W-1:0]         l_addr,
  input  logic [LANE_W*LANES-1:0]   l_wdata,
  output logic [LANE_W*LANES-1:0]   l_rdata,
  output logic [LANES-1:0]          l_drive,
  input  logic                      r_clk,
  input  logic                      r_rst_n,
  input  logic                      r_pipe,
  input  logic                      r_csn,
  input  logic                      r_cs,
  input  logic                      r_rnw,
  input  logic                      r_qen_n,
  input  logic [LANES-1:0]          r_bsel_n,
  input  logic [ADDR_W-1:0]         r_addr,
  input  logic [LANE_W*LANES-1:0]   r_wdata,
  output logic [LANE_W*LANES-1:0]   r_rdata,
  output logic [LANES-1:0]          r_drive
);
  localparam int DATA_W = LANE_W * LANES;

  // Named internal events, brought out for the bound checker.
  logic              l_wr_fire, r_wr_fire;
  logic [LANES-1:0]  l_wr_lanes, r_wr_lanes;

  // Bank read ports: suffix _a is at the left address, _b at the right address.
  logic [DATA_W-1:0] lq_a, lq_b, rq_a, rq_b;
  logic [LANES-1:0]  lf_a, lf_b, rf_a, rf_b;
  logic [DATA_W-1:0] l_word, r_word;

  tps_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .IS_LEFT(1'b1)) u_bank_l (
    .clk      (l_clk),
    .wr_en    (l_wr_fire),
    .wr_lanes (l_wr_lanes),
    .wr_addr  (l_addr),
    .wr_data  (l_wdata),
    .peer_flag(rf_a),
    .rd_addr_a(l_addr),
    .rd_addr_b(r_addr),
    .q_a      (lq_a),
    .q_b      (lq_b),
    .f_a      (lf_a),
    .f_b      (lf_b)
  );

  tps_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .IS_LEFT(1'b0)) u_bank_r (
    .clk      (r_clk),
    .wr_en    (r_wr_fire),
    .wr_lanes (r_wr_lanes),
    .wr_addr  (r_addr),
    .wr_data  (r_wdata),
    .peer_flag(lf_b),
    .rd_addr_a(l_addr),
    .rd_addr_b(r_addr),
    .q_a      (rq_a),
    .q_b      (rq_b),
    .f_a      (rf_a),
    .f_b      (rf_b)
  );

  // Per-lane choice of the newest copy for each port's address.
  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign l_word[g*LANE_W +: LANE_W] = tps_pkg::left_newest(lf_a[g], rf_a[g]) ?
                                        lq_a[g*LANE_W +: LANE_W] : rq_a[g*LANE_W +: LANE_W];
    assign r_word[g*LANE_W +: LANE_W] = tps_pkg::left_newest(lf_b[g], rf_b[g]) ?
                                        lq_b[g*LANE_W +: LANE_W] : rq_b[g*LANE_W +: LANE_W];
  end

  tps_port_pipe #(.LANE_W(LANE_W), .LANES(LANES)) u_pipe_l (
    .clk     (l_clk),
    .rst_n   (l_rst_n),
    .pipe    (l_pipe),
    .csn     (l_csn),
    .cs      (l_cs),
    .rnw     (l_rnw),
    .qen_n   (l_qen_n),
    .bsel_n  (l_bsel_n),
    .mem_word(l_word),
    .rdata   (l_rdata),
    .drive   (l_drive),
    .wr_fire (l_wr_fire),
    .wr_lanes(l_wr_lanes)
  );

  tps_port_pipe #(.LANE_W(LANE_W), .LANES(LANES)) u_pipe_r (
    .clk     (r_clk),
    .rst_n   (r_rst_n),
    .pipe    (r_pipe),
    .csn     (r_csn),
    .cs      (r_cs),
    .rnw     (r_rnw),
    .qen_n   (r_qen_n),
    .bsel_n  (r_bsel_n),
    .mem_word(r_word),
    .rdata   (r_rdata),
    .drive   (r_drive),
    .wr_fire (r_wr_fire),
    .wr_lanes(r_wr_lanes)
  );

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int LANES = 2
) (
  input logic             l_clk,
  input logic             l_rst_n,
  input logic             l_pipe,
  input logic             l_csn,
  input logic             l_cs,
  input logic             l_rnw,
  input logic             l_qen_n,
  input logic [LANES-1:0] l_bsel_n,
  input logic [LANES-1:0] l_drive,
  input logic             l_wr_fire,
  input logic             r_clk,
  input logic             r_rst_n,
  input logic             r_qen_n,
  input logic [LANES-1:0] r_bsel_n,
  input logic [LANES-1:0] r_drive
);

  // R7: output enable high leaves no lane driven.
  a_r7_left_qen_blanks: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    l_qen_n |-> l_drive == '0);
  a_r7_right_qen_blanks: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_qen_n |-> r_drive == '0);

  // R5: all byte selects high at an edge means nothing driven after it.
  a_r5_left_no_lane: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (&l_bsel_n) |=> l_drive == '0);
  a_r5_right_no_lane: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (&r_bsel_n) |=> r_drive == '0);

  // R2 / R8: in flow-through mode a deselect clears the drive after one edge.
  a_r8_flow_deselect: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (!l_pipe && !tps_pkg::port_on(l_csn, l_cs)) |=> (l_pipe || l_drive == '0));

  // R9: in pipelined mode a deselect clears the drive two edges later.
  a_r9_pipe_deselect: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (l_pipe && !tps_pkg::port_on(l_csn, l_cs)) |=> ##1 (!l_pipe || l_drive == '0));

  // R6: a write cycle in flow-through mode leaves the outputs undriven.
  a_r6_write_quiet: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (!l_pipe && l_wr_fire) |=> (l_pipe || l_drive == '0));

  // R8: a full-width flow-through read drives every lane after one edge.
  a_r8_flow_read_drives: assert property (@(posedge l_clk) disable iff (!l_rst_n)
    (!l_pipe && tps_pkg::port_on(l_csn, l_cs) && l_rnw && l_bsel_n == '0 && !l_qen_n)
    |=> (l_pipe || l_qen_n || l_drive == '1));

endmodule

bind twin_port_sram tps_checker #(.LANES(LANES)) u_chk (
  .l_clk    (l_clk),
  .l_rst_n  (l_rst_n),
  .l_pipe   (l_pipe),
  .l_csn    (l_csn),
  .l_cs     (l_cs),
  .l_rnw    (l_rnw),
  .l_qen_n  (l_qen_n),
  .l_bsel_n (l_bsel_n),
  .l_drive  (l_drive),
  .l_wr_fire(l_wr_fire),
  .r_clk    (r_clk),
  .r_rst_n  (r_rst_n),
  .r_qen_n  (r_qen_n),
  .r_bsel_n (r_bsel_n),
  .r_drive  (r_drive)
);

// File: tb/twin_port_sram_test.sv
module twin_port_sram_test;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;   // 125 MHz

  logic        l_pipe, l_csn, l_cs, l_rnw, l_qen_n;
  logic [1:0]  l_bsel_n, l_drive;
  logic [AW-1:0] l_addr;
  logic [17:0] l_wdata, l_rdata;
  logic        r_pipe, r_csn, r_cs, r_rnw, r_qen_n;
  logic [1:0]  r_bsel_n, r_drive;
  logic [AW-1:0] r_addr;
  logic [17:0] r_wdata, r_rdata;

  twin_port_sram #(.LANE_W(9), .LANES(2), .ADDR_W(AW)) uut (
    .l_clk(clk), .l_rst_n(rst_n), .l_pipe(l_pipe), .l_csn(l_csn), .l_cs(l_cs),
    .l_rnw(l_rnw), .l_qen_n(l_qen_n), .l_bsel_n(l_bsel_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
    .r_clk(clk), .r_rst_n(rst_n), .r_pipe(r_pipe), .r_csn(r_csn), .r_cs(r_cs),
    .r_rnw(r_rnw), .r_qen_n(r_qen_n), .r_bsel_n(r_bsel_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [17:0] mirror [WORDS];

  function automatic logic [17:0] pat(input int a, input int s);
    int v;
    v = (a * 7919 + s * 1031 + 3) ^ (a << 12) ^ (s << 7);
    return v[17:0];
  endfunction

  // Lane k set in the enable vector covers bits 9k+8..9k.
  function automatic logic [17:0] lane_bits(input logic [1:0] en);
    return {{9{en[1]}}, {9{en[0]}}};
  endfunction

  function automatic logic [17:0] merge(input logic [17:0] old_w, input logic [17:0] new_w,
                                        input logic [1:0] bsel_n);
    logic [17:0] m;
    m = lane_bits(~bsel_n);
    return (old_w & ~m) | (new_w & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic lset(input logic csn, input logic cs, input logic rnw,
                      input logic [1:0] bs, input int a, input logic [17:0] d);
    l_csn = csn; l_cs = cs; l_rnw = rnw; l_bsel_n = bs; l_addr = a[AW-1:0]; l_wdata = d;
  endtask

  task automatic rset(input logic csn, input logic cs, input logic rnw,
                      input logic [1:0] bs, input int a, input logic [17:0] d);
    r_csn = csn; r_cs = cs; r_rnw = rnw; r_bsel_n = bs; r_addr = a[AW-1:0]; r_wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [17:0] old_w;
    rst_n = 1'b0;
    l_pipe = 0; r_pipe = 0; l_qen_n = 0; r_qen_n = 0;
    lset(1, 0, 1, 2'b11, 0, 0);
    rset(1, 0, 1, 2'b11, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 reset left drive", l_drive, 2'b00);
    chk("R1 reset right drive", r_drive, 2'b00);
    rst_n = 1'b1;
    tick();
    chk("R1 idle after reset", {l_drive, r_drive}, 4'b0000);

    // Fill every word from the left, read every word from the right (R11).
    for (int a = 0; a < WORDS; a++) begin
      lset(0, 1, 0, 2'b00, a, pat(a, 1));
      mirror[a] = pat(a, 1);
      tick();
    end
    lset(1, 0, 1, 2'b11, 0, 0);
    for (int a = 0; a < WORDS; a++) begin
      rset(0, 1, 1, 2'b00, a, 0);
      tick();
      chk("R11 cross-port read", {r_drive, r_rdata}, {2'b11, mirror[a]});
    end

    // Lane-masked writes from the right, lane by address parity (R3).
    for (int a = 0; a < WORDS; a++) begin
      logic [1:0] bs;
      bs = a[0] ? 2'b01 : 2'b10;
      rset(0, 1, 0, bs, a, pat(a, 2));
      mirror[a] = merge(mirror[a], pat(a, 2), bs);
      tick();
    end
    rset(1, 0, 1, 2'b11, 0, 0);
    for (int a = 0; a < WORDS; a++) begin
      lset(0, 1, 1, 2'b00, a, 0);
      tick();
      chk("R3 masked write kept other lane", {l_drive, l_rdata}, {2'b11, mirror[a]});
    end

    // Masked reads (R4) and no-lane access (R5).
    lset(0, 1, 1, 2'b01, 5, 0); tick();
    chk("R4 upper-only read", {l_drive, l_rdata & lane_bits(2'b10)},
        {2'b10, mirror[5] & lane_bits(2'b10)});
    lset(0, 1, 1, 2'b10, 5, 0); tick();
    chk("R4 lower-only read", {l_drive, l_rdata & lane_bits(2'b01)},
        {2'b01, mirror[5] & lane_bits(2'b01)});
    lset(0, 1, 1, 2'b11, 5, 0); tick();
    chk("R5 no-lane read undriven", l_drive, 2'b00);
    lset(0, 1, 0, 2'b11, 6, ~mirror[6]); tick();
    lset(0, 1, 1, 2'b00, 6, 0); tick();
    chk("R5 no-lane write kept word", {l_drive, l_rdata}, {2'b11, mirror[6]});

    // Deselect by either chip select (R2).
    lset(1, 1, 1, 2'b00, 5, 0); tick();
    chk("R2 csn high undriven", l_drive, 2'b00);
    lset(0, 0, 1, 2'b00, 5, 0); tick();
    chk("R2 cs low undriven", l_drive, 2'b00);
    lset(1, 1, 0, 2'b00, 7, ~mirror[7]); tick();
    lset(0, 0, 0, 2'b00, 7, ~mirror[7]); tick();
    lset(0, 1, 1, 2'b00, 7, 0); tick();
    chk("R2 deselected writes ignored", {l_drive, l_rdata}, {2'b11, mirror[7]});

    // Write cycle leaves own outputs quiet (R6).
    lset(0, 1, 1, 2'b00, 8, 0); tick();
    chk("R6 read before write", l_drive, 2'b11);
    lset(0, 1, 0, 2'b00, 8, pat(8, 3)); mirror[8] = pat(8, 3); tick();
    chk("R6 write cycle undriven", l_drive, 2'b00);
    lset(0, 1, 1, 2'b00, 8, 0); tick();
    chk("R6 written word reads back", {l_drive, l_rdata}, {2'b11, mirror[8]});

    // Asynchronous output enable (R7).
    lset(0, 1, 1, 2'b00, 9, 0); tick();
    l_qen_n = 1; #1;
    chk("R7 disable without clock", l_drive, 2'b00);
    l_qen_n = 0; #1;
    chk("R7 enable restores read", {l_drive, l_rdata}, {2'b11, mirror[9]});

    // Flow-through latency (R8).
    lset(0, 1, 1, 2'b00, 10, 0); tick();
    chk("R8 flow read after one edge", {l_drive, l_rdata}, {2'b11, mirror[10]});
    lset(1, 0, 1, 2'b00, 0, 0); tick();
    chk("R8 flow deselect after one edge", l_drive, 2'b00);

    // Pipelined latency (R9).
    l_pipe = 1;
    tick(); tick();
    lset(0, 1, 1, 2'b00, 11, 0); tick();
    chk("R9 pipe not valid after one edge", l_drive, 2'b00);
    lset(0, 1, 1, 2'b00, 12, 0); tick();
    chk("R9 pipe read after two edges", {l_drive, l_rdata}, {2'b11, mirror[11]});
    lset(1, 0, 1, 2'b00, 0, 0); tick();
    chk("R9 pipe deselect still driving", {l_drive, l_rdata}, {2'b11, mirror[12]});
    tick();
    chk("R9 pipe deselect after two edges", l_drive, 2'b00);

    // Single-stage lane selects in pipelined mode (R10).
    lset(0, 1, 1, 2'b00, 13, 0); tick();
    lset(1, 0, 1, 2'b01, 0, 0); tick();
    chk("R10 pipe lane mask from latest edge", {l_drive, l_rdata & lane_bits(2'b10)},
        {2'b10, mirror[13] & lane_bits(2'b10)});
    lset(1, 0, 1, 2'b00, 0, 0); tick();
    chk("R10 pipe drained", l_drive, 2'b00);
    l_pipe = 0;
    lset(1, 0, 1, 2'b11, 0, 0); tick();

    // Pipelined sweep on the right port (R9).
    r_pipe = 1;
    for (int a = 0; a < WORDS; a++) begin
      rset(0, 1, 1, 2'b00, a, 0);
      tick();
      if (a > 0) chk("R9 pipe sweep", {r_drive, r_rdata}, {2'b11, mirror[a-1]});
    end
    rset(1, 0, 1, 2'b00, 0, 0); tick();
    chk("R9 pipe sweep last word", {r_drive, r_rdata}, {2'b11, mirror[WORDS-1]});
    tick();
    chk("R9 pipe sweep drained", r_drive, 2'b00);
    r_pipe = 0;
    rset(1, 0, 1, 2'b11, 0, 0); tick();

    // Simultaneous accesses (R11).
    lset(0, 1, 0, 2'b00, 20, pat(20, 5)); mirror[20] = pat(20, 5);
    rset(0, 1, 0, 2'b00, 21, pat(21, 6)); mirror[21] = pat(21, 6);
    tick();
    lset(1, 0, 1, 2'b11, 0, 0);
    rset(0, 1, 1, 2'b00, 20, 0); tick();
    chk("R11 dual write left word", {r_drive, r_rdata}, {2'b11, mirror[20]});
    rset(0, 1, 1, 2'b00, 21, 0); tick();
    chk("R11 dual write right word", {r_drive, r_rdata}, {2'b11, mirror[21]});
    old_w = mirror[22];
    lset(0, 1, 0, 2'b00, 22, pat(22, 7)); mirror[22] = pat(22, 7);
    rset(0, 1, 1, 2'b00, 22, 0); tick();
    n_chk++;
    if (r_drive !== 2'b11 || (r_rdata !== old_w && r_rdata !== mirror[22])) begin
      n_bad++;
      $display("FAIL R11 same-cycle read actual=%h expected=%h or %h", r_rdata, old_w, mirror[22]);
    end
    lset(1, 0, 1, 2'b11, 0, 0);
    rset(0, 1, 1, 2'b00, 22, 0); tick();
    chk("R11 read after overlap", {r_drive, r_rdata}, {2'b11, mirror[22]});

    finish_run();
  end

endmodule